// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block sits between the pins of a parallel NOR-style memory model and its internal command logic. Every rising edge of `clk` samples the active-low chip enable, output enable and write enable pins with the address and data buses. The block turns each sample into one bus operation: read, write, standby, output disable, or a conflict in which both enables are low. It then drives the data bus through split value and per-bit enable outputs.

The data bus is 16 bits wide when `wide_mode` is high. When `wide_mode` is low, data moves on the low eight lines only. The upper eight lines then stop driving, and the top data line becomes an input that carries the address bit below `addr[0]`. That bit picks the high or low half of the addressed word. A write is a window in which chip enable and write enable are low while output enable is high. The address is captured when the window opens and the data when it closes. The downstream command state machine then receives a one-cycle strobe with both. Reads return a small behavioural array until the command logic switches the read source with `sm_read_sel`. The array is loaded through a separate program port.

Top module: `pfb_bus_front`

## Requirements
- R1: While `reset_n` is low, `dq_oe` and `dq_o` are all zero, `cmd_valid` is low and `cmd_addr`, `cmd_data`, `cmd_byte` are zero. The pins are treated as idle until the first edge after release.
- R2: If the pins sampled at an edge show chip enable low, output enable low, write enable high and `wide_mode` high, then after that edge `dq_oe` is all ones and `dq_o` carries the full read word.
- R3: The same read with `wide_mode` low gives `dq_oe` = 0x00FF and `dq_o[15:8]` = 0. `dq_o[7:0]` is the read word's low half when the sampled `dq_i[15]` is 0 and its high half when it is 1.
- R4: A sample with chip enable high (standby) gives `dq_oe` = 0 and `dq_o` = 0 after that edge, whatever the other pins are.
- R5: A sample with chip enable low and both output enable and write enable high (output disable) gives `dq_oe` = 0 after that edge.
- R6: Driving `reset_n` low sets `dq_oe` to zero at once, without waiting for a clock edge, even while a read is in progress.
- R7: The write window opens at the first sample in which the write condition holds and closes at the first later sample in which it does not. `cmd_valid` is high for exactly the one cycle after the edge that samples the close.
- R8: `cmd_addr` is `{addr, lsb}`, with `addr` and `lsb` taken at the opening sample. `lsb` is `dq_i[15]` in byte mode and 0 in word mode. `cmd_data` is the `dq_i` of the last sample inside the window, with its upper byte forced to zero in byte mode. `cmd_byte` is 1 for a byte-mode write. The three fields hold until the next strobe.
- R9: After reset, reads return the array with no command needed. A bus write never changes the array. With `sm_read_sel` high, reads return `sm_read_data` through the same word or byte lane selection.
- R10: A sample with chip enable, output enable and write enable all low drives nothing and never opens a write window.
- R11: `prog_we` high at an edge stores `prog_data` in the array word at `prog_addr`. Array reads index the word with the low `$clog2(ARRAY_DEPTH)` bits of `addr`, and a read sampled at that same edge already sees the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| reset_n | input | 1 | Active-low hardware reset, asynchronous |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| wide_mode | input | 1 | 1 = 16-bit word bus, 0 = 8-bit byte bus |
| addr | input | 17 | Word address |
| dq_i | input | 16 | Data bus input value; bit 15 is the extra low address bit in byte mode |
| dq_o | output | 16 | Data bus drive value, zero where not driven |
| dq_oe | output | 16 | Per-line drive enable of the data bus |
| sm_read_sel | input | 1 | 1 = reads return `sm_read_data` instead of the array |
| sm_read_data | input | 16 | Word supplied by the command logic for non-array reads |
| prog_we | input | 1 | Array word write strobe from the command logic |
| prog_addr | input | 6 | Array word index for `prog_we` |
| prog_data | input | 16 | Array word to store |
| cmd_valid | output | 1 | One-cycle strobe for a completed bus write |
| cmd_addr | output | 18 | Captured byte address of the last write |
| cmd_data | output | 16 | Captured data of the last write |
| cmd_byte | output | 1 | Last write was made in byte mode |

## Verification
On every clock the assertions check the drive-enable pattern that follows each sampled pin combination: full bus for word reads, low lanes for byte reads, and nothing for standby, output disable, conflicts and reset. They also check that the write strobe never lasts two cycles. Whether the right word or half-word is selected, whether a write window captures its address at the opening and its data at the closing, and whether bus writes leave the array untouched can only be shown by the bench's scenarios. The bench compares these against its own model of the array and of the command register on every clock.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        OP_STANDBY  = 3'd0,
        OP_OUT_DIS  = 3'd1,
        OP_READ     = 3'd2,
        OP_WRITE    = 3'd3,
        OP_CONFLICT = 3'd4
    } bus_op_e;

endpackage

// File: rtl/pfb_op_decode.sv
module pfb_op_decode
    import pfb_pkg::*;
(
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    output bus_op_e op
);

    always_comb begin
        if (ce_n) begin
            op = OP_STANDBY;
        end else begin
            unique case ({oe_n, we_n})
                2'b01:   op = OP_READ;
                2'b10:   op = OP_WRITE;
                2'b11:   op = OP_OUT_DIS;
                default: op = OP_CONFLICT;
            endcase
        end
    end

endmodule

// File: rtl/pfb_pin_sampler.sv
module pfb_pin_sampler #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              reset_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic              cur_ce_n,
    output logic              cur_oe_n,
    output logic              cur_we_n,
    output logic              cur_wide,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_lsb,
    output logic              prv_ce_n,
    output logic              prv_oe_n,
    output logic              prv_we_n,
    output logic [DATA_W-1:0] prv_dq
);

    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dq;
    } cur_t;

    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [DATA_W-1:0] dq;
    } prv_t;

    typedef struct packed {
        cur_t cur;
        prv_t prv;
    } smp_t;

    localparam cur_t CUR_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                  wide: 1'b1, addr: '0, dq: '0};
    localparam prv_t PRV_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq: '0};

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.cur.ce_n = ce_n;
        smp_d.cur.oe_n = oe_n;
        smp_d.cur.we_n = we_n;
        smp_d.cur.wide = wide_mode;
        smp_d.cur.addr = addr;
        smp_d.cur.dq   = dq_i;
        smp_d.prv.ce_n = smp_q.cur.ce_n;
        smp_d.prv.oe_n = smp_q.cur.oe_n;
        smp_d.prv.we_n = smp_q.cur.we_n;
        smp_d.prv.dq   = smp_q.cur.dq;
    end

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) begin
            smp_q.cur <= CUR_IDLE;
            smp_q.prv <= PRV_IDLE;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign cur_ce_n = smp_q.cur.ce_n;
    assign cur_oe_n = smp_q.cur.oe_n;
    assign cur_we_n = smp_q.cur.we_n;
    assign cur_wide = smp_q.cur.wide;
    assign cur_addr = smp_q.cur.addr;
    assign cur_lsb  = smp_q.cur.dq[DATA_W-1];
    assign prv_ce_n = smp_q.prv.ce_n;
    assign prv_oe_n = smp_q.prv.oe_n;
    assign prv_we_n = smp_q.prv.we_n;
    assign prv_dq   = smp_q.prv.dq;

endmodule

// File: rtl/pfb_write_latch.sv
module pfb_write_latch
    import pfb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              reset_n,
    input  bus_op_e           cur_op,
    input  bus_op_e           prv_op,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_lsb,
    input  logic              cur_wide,
    input  logic [DATA_W-1:0] prv_dq,
    output logic              cmd_valid,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_byte
);

    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W:0]   addr;
        logic [DATA_W-1:0] data;
        logic              byte_md;
        logic [ADDR_W:0]   pend_addr;
        logic              pend_byte;
    } wl_t;

    wl_t wl_d, wl_q;
    logic win_open, win_close;

    always_comb begin
        win_open  = (cur_op == OP_WRITE) && (prv_op != OP_WRITE);
        win_close = (prv_op == OP_WRITE) && (cur_op != OP_WRITE);

        wl_d     = wl_q;
        wl_d.vld = 1'b0;

        if (win_open) begin
            wl_d.pend_addr = {cur_addr, (cur_wide ? 1'b0 : cur_lsb)};
            wl_d.pend_byte = !cur_wide;
        end

        if (win_close) begin
            wl_d.vld     = 1'b1;
            wl_d.addr    = wl_q.pend_addr;
            wl_d.byte_md = wl_q.pend_byte;
            if (wl_q.pend_byte) begin
                wl_d.data = {{HALF{1'b0}}, prv_dq[HALF-1:0]};
            end else begin
                wl_d.data = prv_dq;
            end
        end
    end

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) begin
            wl_q <= '0;
        end else begin
            wl_q <= wl_d;
        end
    end

    assign cmd_valid = wl_q.vld;
    assign cmd_addr  = wl_q.addr;
    assign cmd_data  = wl_q.data;
    assign cmd_byte  = wl_q.byte_md;

endmodule

// File: rtl/pfb_read_path.sv
module pfb_read_path
    import pfb_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ARRAY_DEPTH = 64,
    localparam int IDX_W      = $clog2(ARRAY_DEPTH)
) (
    input  logic              clk,
    input  bus_op_e           cur_op,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic              cur_wide,
    input  logic              cur_lsb,
    input  logic              sm_read_sel,
    input  logic [DATA_W-1:0] sm_read_data,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] dq_oe
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] mem_q [ARRAY_DEPTH];
    logic [DATA_W-1:0] rd_word;
    logic [HALF-1:0]   rd_half;

    always_ff @(posedge clk) begin
        if (prog_we) begin
            mem_q[prog_addr] <= prog_data;
        end
    end

    always_comb begin
        rd_word = sm_read_sel ? sm_read_data : mem_q[cur_idx];
        rd_half = cur_lsb ? rd_word[DATA_W-1:HALF] : rd_word[HALF-1:0];

        dq_o  = '0;
        dq_oe = '0;
        if (cur_op == OP_READ) begin
            if (cur_wide) begin
                dq_o  = rd_word;
                dq_oe = '1;
            end else begin
                dq_o[HALF-1:0]  = rd_half;
                dq_oe[HALF-1:0] = '1;
            end
        end
    end

endmodule

// File: rtl/pfb_bus_front.sv
module pfb_bus_front
    import pfb_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 17,
    parameter int ARRAY_DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           reset_n,
    input  logic                           ce_n,
    input  logic                           oe_n,
    input  logic                           we_n,
    input  logic                           wide_mode,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              dq_i,
    output logic [DATA_W-1:0]              dq_o,
    output logic [DATA_W-1:0]              dq_oe,
    input  logic                           sm_read_sel,
    input  logic [DATA_W-1:0]              sm_read_data,
    input  logic                           prog_we,
    input  logic [$clog2(ARRAY_DEPTH)-1:0] prog_addr,
    input  logic [DATA_W-1:0]              prog_data,
    output logic                           cmd_valid,
    output logic [ADDR_W:0]                cmd_addr,
    output logic [DATA_W-1:0]              cmd_data,
    output logic                           cmd_byte
);

    localparam int IDX_W  = $clog2(ARRAY_DEPTH);
    localparam int STAGES = 2;

    logic              cur_wide, cur_lsb;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] prv_dq;
    logic [STAGES-1:0] st_ce_n, st_oe_n, st_we_n;
    bus_op_e           st_op [STAGES];

    pfb_pin_sampler #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_sampler (
        .clk       (clk),
        .reset_n   (reset_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .wide_mode (wide_mode),
        .addr      (addr),
        .dq_i      (dq_i),
        .cur_ce_n  (st_ce_n[0]),
        .cur_oe_n  (st_oe_n[0]),
        .cur_we_n  (st_we_n[0]),
        .cur_wide  (cur_wide),
        .cur_addr  (cur_addr),
        .cur_lsb   (cur_lsb),
        .prv_ce_n  (st_ce_n[1]),
        .prv_oe_n  (st_oe_n[1]),
        .prv_we_n  (st_we_n[1]),
        .prv_dq    (prv_dq)
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_decode
        pfb_op_decode u_dec (
            .ce_n (st_ce_n[g]),
            .oe_n (st_oe_n[g]),
            .we_n (st_we_n[g]),
            .op   (st_op[g])
        );
    end

    pfb_write_latch #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_wlatch (
        .clk       (clk),
        .reset_n   (reset_n),
        .cur_op    (st_op[0]),
        .prv_op    (st_op[1]),
        .cur_addr  (cur_addr),
        .cur_lsb   (cur_lsb),
        .cur_wide  (cur_wide),
        .prv_dq    (prv_dq),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .cmd_byte  (cmd_byte)
    );

    pfb_read_path #(
        .DATA_W      (DATA_W),
        .ARRAY_DEPTH (ARRAY_DEPTH)
    ) u_rpath (
        .clk          (clk),
        .cur_op       (st_op[0]),
        .cur_idx      (cur_addr[IDX_W-1:0]),
        .cur_wide     (cur_wide),
        .cur_lsb      (cur_lsb),
        .sm_read_sel  (sm_read_sel),
        .sm_read_data (sm_read_data),
        .prog_we      (prog_we),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .dq_o         (dq_o),
        .dq_oe        (dq_oe)
    );

endmodule

// File: rtl/pfb_bus_chk.sv
module pfb_bus_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              reset_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              wide_mode,
    input logic [DATA_W-1:0] dq_oe,
    input logic              cmd_valid
);

    localparam logic [DATA_W-1:0] LOW_LANES = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

    logic live_q;

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) live_q <= 1'b0;
        else          live_q <= 1'b1;
    end

    always @(posedge clk) begin
        if (!reset_n) begin
            assert_quiet_in_reset_R1: assert (dq_oe == '0 && !cmd_valid)
                else $error("bus driven or strobe high during reset");
        end
    end

    assert_word_read_R2: assert property (@(posedge clk) disable iff (!reset_n)
        (live_q && $past(!ce_n && !oe_n && we_n && wide_mode)) |-> (dq_oe == '1));

    assert_byte_lanes_R3: assert property (@(posedge clk) disable iff (!reset_n)
        (live_q && $past(!ce_n && !oe_n && we_n && !wide_mode)) |-> (dq_oe == LOW_LANES));

    assert_standby_float_R4: assert property (@(posedge clk) disable iff (!reset_n)
        (live_q && $past(ce_n)) |-> (dq_oe == '0));

    assert_out_disable_R5: assert property (@(posedge clk) disable iff (!reset_n)
        (live_q && $past(!ce_n && oe_n && we_n)) |-> (dq_oe == '0));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!reset_n)
        cmd_valid |=> !cmd_valid);

    assert_conflict_float_R10: assert property (@(posedge clk) disable iff (!reset_n)
        (live_q && $past(!ce_n && !oe_n && !we_n)) |-> (dq_oe == '0));

endmodule

bind pfb_bus_front pfb_bus_chk #(.DATA_W(DATA_W)) u_bus_chk (
    .clk       (clk),
    .reset_n   (reset_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .wide_mode (wide_mode),
    .dq_oe     (dq_oe),
    .cmd_valid (cmd_valid)
);

// File: tb/pfb_bus_front_tb_top.sv
module pfb_bus_front_tb_top;

    logic        clk = 1'b0;
    logic        reset_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide_mode = 1'b1;
    logic [16:0] addr = '0;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o, dq_oe;
    logic        sm_read_sel = 1'b0;
    logic [15:0] sm_read_data = '0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic        cmd_valid, cmd_byte;
    logic [17:0] cmd_addr;
    logic [15:0] cmd_data;

    always #4 clk = ~clk;

    pfb_bus_front dut_i (
        .clk(clk), .reset_n(reset_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wide_mode(wide_mode), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .sm_read_sel(sm_read_sel), .sm_read_data(sm_read_data),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_byte(cmd_byte)
    );

    int    checks = 0, errors = 0, pulses = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural model state
    int mem [64];
    int s_ce, s_oe, s_we, s_wide, s_addr, s_dq;
    int p_ce, p_oe, p_we, p_dq;
    int e_vld, e_addr, e_data, e_byte, pend_addr, pend_byte;

    function automatic bit is_wr(int ce, int oe, int we);
        return (ce == 0) && (we == 0) && (oe == 1);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        s_ce = 1; s_oe = 1; s_we = 1; s_wide = 1; s_addr = 0; s_dq = 0;
        p_ce = 1; p_oe = 1; p_we = 1; p_dq = 0;
        e_vld = 0; e_addr = 0; e_data = 0; e_byte = 0; pend_addr = 0; pend_byte = 0;
    endtask

    task automatic model_edge();
        bit opening, closing;
        if (prog_we) mem[int'(prog_addr)] = int'(prog_data);
        if (!reset_n) begin
            model_clear();
        end else begin
            opening = is_wr(s_ce, s_oe, s_we) && !is_wr(p_ce, p_oe, p_we);
            closing = is_wr(p_ce, p_oe, p_we) && !is_wr(s_ce, s_oe, s_we);
            e_vld = closing ? 1 : 0;
            if (closing) begin
                e_addr = pend_addr;
                e_byte = pend_byte;
                e_data = pend_byte ? (p_dq & 'hFF) : p_dq;
            end
            if (opening) begin
                pend_addr = s_addr * 2 + (s_wide ? 0 : ((s_dq >> 15) & 1));
                pend_byte = s_wide ? 0 : 1;
            end
            p_ce = s_ce; p_oe = s_oe; p_we = s_we; p_dq = s_dq;
            s_ce = int'(ce_n); s_oe = int'(oe_n); s_we = int'(we_n);
            s_wide = int'(wide_mode); s_addr = int'(addr); s_dq = int'(dq_i);
        end
    endtask

    task automatic compare();
        int word, exp_oe, exp_o;
        bit rd;
        rd   = (s_ce == 0) && (s_oe == 0) && (s_we == 1);
        word = sm_read_sel ? int'(sm_read_data) : mem[s_addr % 64];
        exp_oe = 0; exp_o = 0;
        if (rd) begin
            if (s_wide) begin
                exp_oe = 'hFFFF; exp_o = word;
            end else begin
                exp_oe = 'h00FF;
                exp_o  = ((s_dq >> 15) & 1) ? ((word >> 8) & 'hFF) : (word & 'hFF);
            end
        end
        chk(cur_req, "dq_oe", int'(dq_oe), exp_oe);
        chk(cur_req, "dq_o", int'(dq_o), exp_o);
        chk(cur_req, "cmd_valid", int'(cmd_valid), e_vld);
        chk(cur_req, "cmd_addr", int'(cmd_addr), e_addr);
        chk(cur_req, "cmd_data", int'(cmd_data), e_data);
        chk(cur_req, "cmd_byte", int'(cmd_byte), e_byte);
        if (cmd_valid) pulses++;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        compare();
    endtask

    task automatic pins(bit ce, bit oe, bit we, bit wide, int a, int d);
        ce_n = ce; oe_n = oe; we_n = we; wide_mode = wide;
        addr = 17'(a); dq_i = 16'(d);
    endtask

    task automatic idle(int n);
        pins(1, 1, 1, wide_mode, 0, 0);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        model_clear();
        for (int i = 0; i < 64; i++) mem[i] = 0;

        // R1: reset state
        cur_req = "R1";
        pins(0, 0, 1, 1, 3, 0);
        for (int i = 0; i < 3; i++) tick();
        chk("R1", "dq_oe in reset", int'(dq_oe), 0);
        reset_n = 1'b1;
        pins(1, 1, 1, 1, 0, 0);
        tick();

        // R11: load array through program port
        cur_req = "R11";
        for (int i = 0; i < 64; i++) begin
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = 16'((i * 'h0101) ^ 'hA5C3);
            tick();
        end
        prog_we = 1'b0;
        tick();

        // R2: word reads, several addresses incl. both ends and an aliased one
        cur_req = "R2";
        foreach (mem[k]) if (k % 9 == 0) begin
            pins(0, 0, 1, 1, k, 0); tick();
        end
        pins(0, 0, 1, 1, 63, 0); tick();
        chk("R2", "word read addr 63", int'(dq_o), (63 * 'h0101) ^ 'hA5C3);
        pins(0, 0, 1, 1, 64 + 5, 0); tick();
        chk("R11", "aliased index 69->5", int'(dq_o), (5 * 'h0101) ^ 'hA5C3);

        // R3: byte reads both halves
        cur_req = "R3";
        pins(0, 0, 1, 0, 10, 'h0000); tick();
        chk("R3", "low half", int'(dq_o), ((10 * 'h0101) ^ 'hA5C3) & 'hFF);
        pins(0, 0, 1, 0, 10, 'h8000); tick();
        chk("R3", "high half", int'(dq_o), (((10 * 'h0101) ^ 'hA5C3) >> 8) & 'hFF);
        chk("R3", "lane enables", int'(dq_oe), 'h00FF);
        pins(0, 0, 1, 0, 33, 'hFFFF); tick();

        // R4: standby with other pins active
        cur_req = "R4";
        pins(1, 0, 1, 1, 4, 0); tick();
        chk("R4", "standby dq_oe", int'(dq_oe), 0);
        pins(1, 0, 0, 0, 4, 'h8000); tick();

        // R5: output disable
        cur_req = "R5";
        pins(0, 1, 1, 1, 7, 0); tick();
        chk("R5", "out disable dq_oe", int'(dq_oe), 0);

        // R10: conflict, no write window
        cur_req = "R10";
        pulses = 0;
        pins(0, 0, 0, 1, 9, 'h1234); tick(); tick();
        idle(3);
        chk("R10", "no strobe from conflict", pulses, 0);

        // R7/R8: word write, 3-sample window, data changes inside window
        cur_req = "R7";
        pulses = 0;
        idle(1);
        pins(0, 1, 0, 1, 'h1ABCD, 'h1111); tick();
        pins(0, 1, 0, 1, 'h00002, 'h2222); tick();
        pins(0, 1, 0, 1, 'h00002, 'hBEEF); tick();
        pins(0, 1, 1, 1, 0, 0); tick();
        tick();
        chk("R7", "strobe one cycle after close", int'(cmd_valid), 1);
        chk("R8", "word cmd_addr", int'(cmd_addr), 'h1ABCD * 2);
        chk("R8", "word cmd_data", int'(cmd_data), 'hBEEF);
        idle(3);
        chk("R7", "single strobe", pulses, 1);
        chk("R8", "fields hold", int'(cmd_data), 'hBEEF);

        // R8: byte write, upper half of word 0x21
        cur_req = "R8";
        pins(0, 1, 0, 0, 'h21, 'h805A); tick();
        pins(0, 1, 0, 0, 'h21, 'h7F5A); tick();
        idle(2);
        chk("R8", "byte cmd_addr", int'(cmd_addr), 'h21 * 2 + 1);
        chk("R8", "byte cmd_data", int'(cmd_data), 'h005A);
        chk("R8", "byte flag", int'(cmd_byte), 1);

        // R9: bus writes leave the array alone; alternate read source
        cur_req = "R9";
        pins(0, 0, 1, 1, 2, 0); tick();
        chk("R9", "array unchanged by write", int'(dq_o), (2 * 'h0101) ^ 'hA5C3);
        sm_read_sel = 1'b1; sm_read_data = 16'h0080;
        pins(0, 0, 1, 1, 2, 0); tick();
        chk("R9", "alt source word", int'(dq_o), 'h0080);
        pins(0, 0, 1, 0, 2, 'h8000); tick();
        chk("R9", "alt source high byte", int'(dq_o), 'h00);
        sm_read_sel = 1'b0;
        pins(0, 0, 1, 0, 2, 0); tick();

        // R11: program and read same index at same edge
        cur_req = "R11";
        prog_we = 1'b1; prog_addr = 6'd12; prog_data = 16'h5A5A;
        pins(0, 0, 1, 1, 12, 0); tick();
        prog_we = 1'b0;
        chk("R11", "new word visible", int'(dq_o), 'h5A5A);
        tick();

        // R6: reset during a read floats the bus at once
        cur_req = "R6";
        pins(0, 0, 1, 1, 12, 0); tick();
        reset_n = 1'b0;
        #1;
        chk("R6", "dq_oe right after reset", int'(dq_oe), 0);
        chk("R6", "cmd_data cleared", int'(cmd_data), 0);
        tick(); tick();
        reset_n = 1'b1;
        tick(); tick();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule